// File: doc/BRIEF.md
# AXI4-Lite Three-Class Register Bank

This block is an AXI4-Lite slave that gives a datapath module a bank of software-visible 32-bit registers. The registers fall into three access classes, and each class has its own parameter for its count. One class is written by software and consumed by hardware only. The second is written by software and read by both software and hardware. The third is produced by hardware and read by software.

All three classes share a single contiguous window of word addresses. The hardware side sees each class as one flat packed bus. The bus for each software-written class is driven from flops inside the bank. The bus for the hardware-produced class is an input that the bank samples when a software read is accepted.

The bank accepts one write and one read at a time. Write address and write data may arrive in either order. Both byte strobes and error responses are supported. Reset asserts asynchronously, is released synchronously, and clears every software-writable register.

Top module: `regbank_axil`

## Requirements
- R1: Word index is the address divided by four. Words 0 to N_WO-1 are write-only registers, the next N_RW words are read/write registers, the next N_RO words are read-only registers, and a class with count zero takes no words.
- R2: Within its class bus, register k of that class occupies bits [32*k+31 : 32*k].
- R3: A write to a write-only register updates its slot on `wo_bus`. A read of a write-only register returns data 0 with response OKAY (2'b00).
- R4: A write to a read/write register updates its slot on `rw_bus`, and a later read of that register returns the stored value with OKAY.
- R5: A read of a read-only register returns the value of its `ro_bus` slot as sampled at the read-address handshake, with OKAY. A write to a read-only register gets OKAY and changes no register.
- R6: Only the bytes whose `wstrb` bit is 1 are updated; bit b of `wstrb` covers data bits [8*b+7 : 8*b].
- R7: A write commits only after both its address and its data have been accepted, in either order. The commit produces exactly one write response, and that response is held with a stable `bresp` until `bready` is high. `awready` and `wready` stay low while a response is pending.
- R8: An access whose word index is at or beyond N_WO+N_RW+N_RO, or whose two low address bits are not zero, gets SLVERR (2'b10). Such a read returns data 0, and such a write changes no register.
- R9: While `rvalid` is high and `rready` is low, `rdata` and `rresp` hold their values even if `ro_bus` changes. `arready` is low while `rvalid` is high.
- R10: Driving `aresetn` low clears `wo_bus` and `rw_bus` at once and drops `bvalid` and `rvalid`. Release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Active-low reset, asynchronous assert |
| axil_awaddr | input | ADDR_W | Write byte address |
| axil_awvalid | input | 1 | Write address valid |
| axil_awready | output | 1 | Write address ready |
| axil_wdata | input | DATA_W | Write data |
| axil_wstrb | input | DATA_W/8 | Write byte enables |
| axil_wvalid | input | 1 | Write data valid |
| axil_wready | output | 1 | Write data ready |
| axil_bresp | output | 2 | Write response code |
| axil_bvalid | output | 1 | Write response valid |
| axil_bready | input | 1 | Write response ready |
| axil_araddr | input | ADDR_W | Read byte address |
| axil_arvalid | input | 1 | Read address valid |
| axil_arready | output | 1 | Read address ready |
| axil_rdata | output | DATA_W | Read data |
| axil_rresp | output | 2 | Read response code |
| axil_rvalid | output | 1 | Read data valid |
| axil_rready | input | 1 | Read data ready |
| wo_bus | output | max(N_WO,1)*DATA_W | Write-only class, packed |
| rw_bus | output | max(N_RW,1)*DATA_W | Read/write class, packed |
| ro_bus | input | max(N_RO,1)*DATA_W | Read-only class, packed, from hardware |

## Verification
The bench builds the bank with ADDR_W=6 and two registers in each class. Two registers per class let the bench tell slot 0 from slot 1 on every packed bus and check the boundary between classes at words 1/2 and 3/4. The 6-bit address gives 16 words of which only six are mapped, so both a just-past-the-end index (word 6 onwards) and the topmost word 15 can be used for SLVERR cases, next to misaligned addresses.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;

  typedef enum logic [1:0] {
    AXI_OKAY   = 2'b00,
    AXI_SLVERR = 2'b10
  } axi_resp_e;

  typedef enum logic [1:0] {
    REG_WO,
    REG_RW,
    REG_RO,
    REG_NONE
  } reg_class_e;

endpackage

// File: rtl/regbank_decode.sv
`timescale 1ns/1ps
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned N_WO   = 2,
  parameter int unsigned N_RW   = 2,
  parameter int unsigned N_RO   = 2,
  parameter int unsigned IDX_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_class_e        cls,
  output logic [IDX_W-1:0]  loc
);

  localparam int unsigned LIM_WO = N_WO;
  localparam int unsigned LIM_RW = N_WO + N_RW;
  localparam int unsigned LIM_RO = N_WO + N_RW + N_RO;

  logic [31:0] word;

  // Class boundaries follow the fixed WO / RW / RO order (R1)
  always_comb begin
    word = 32'(addr[ADDR_W-1:2]);
    cls  = REG_NONE;
    loc  = '0;
    if (addr[1:0] != 2'b00) begin
      cls = REG_NONE;
    end else if (word < LIM_WO) begin
      cls = REG_WO;
      loc = IDX_W'(word);
    end else if (word < LIM_RW) begin
      cls = REG_RW;
      loc = IDX_W'(word - LIM_WO);
    end else if (word < LIM_RO) begin
      cls = REG_RO;
      loc = IDX_W'(word - LIM_RW);
    end
  end

endmodule

// File: rtl/regbank_wr_chan.sv
`timescale 1ns/1ps
module regbank_wr_chan #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [1:0]        resp_in,
  output logic              commit,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [STRB_W-1:0] cmd_strb
);

  logic aw_full_q, aw_full_d;
  logic w_full_q, w_full_d;
  logic bvalid_q, bvalid_d;
  logic [1:0] bresp_q, bresp_d;
  logic aw_take, w_take;

  assign awready = !aw_full_q && !bvalid_q;
  assign wready  = !w_full_q && !bvalid_q;
  assign aw_take = awvalid && awready;
  assign w_take  = wvalid && wready;
  assign commit  = aw_full_q && w_full_q;
  assign bvalid  = bvalid_q;
  assign bresp   = bresp_q;

  always_comb begin
    aw_full_d = aw_full_q;
    w_full_d  = w_full_q;
    bvalid_d  = bvalid_q;
    bresp_d   = bresp_q;
    if (aw_take) aw_full_d = 1'b1;
    if (w_take)  w_full_d  = 1'b1;
    if (commit) begin
      aw_full_d = 1'b0;
      w_full_d  = 1'b0;
      bvalid_d  = 1'b1;
      bresp_d   = resp_in;
    end else if (bvalid_q && bready) begin
      bvalid_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      bresp_q   <= 2'b00;
    end else begin
      aw_full_q <= aw_full_d;
      w_full_q  <= w_full_d;
      bvalid_q  <= bvalid_d;
      bresp_q   <= bresp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr <= '0;
      cmd_data <= '0;
      cmd_strb <= '0;
    end else begin
      if (aw_take) cmd_addr <= awaddr;
      if (w_take) begin
        cmd_data <= wdata;
        cmd_strb <= wstrb;
      end
    end
  end

  // R7: response held with stable code until taken
  a_r7_bresp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid_q && !bready |=> bvalid_q && $stable(bresp_q));

  // R7: a response only appears after both halves were held
  a_r7_resp_after_both: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid_q) |-> $past(aw_full_q) && $past(w_full_q));

endmodule

// File: rtl/regbank_rd_chan.sv
`timescale 1ns/1ps
module regbank_rd_chan #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [1:0]        rd_resp
);

  logic rvalid_q, rvalid_d;
  logic fire;

  assign arready = !rvalid_q;
  assign fire    = arvalid && arready;
  assign rvalid  = rvalid_q;

  always_comb begin
    rvalid_d = rvalid_q;
    if (fire) rvalid_d = 1'b1;
    else if (rvalid_q && rready) rvalid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata    <= '0;
      rresp    <= 2'b00;
    end else begin
      rvalid_q <= rvalid_d;
      if (fire) begin
        rdata <= rd_word;
        rresp <= rd_resp;
      end
    end
  end

  // R9: read beat frozen while stalled
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q && !rready |=> rvalid_q && $stable(rdata) && $stable(rresp));

endmodule

// File: rtl/regbank_axil.sv
`timescale 1ns/1ps
module regbank_axil
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_WO   = 2,
  parameter int unsigned N_RW   = 2,
  parameter int unsigned N_RO   = 2,
  localparam int unsigned STRB_W  = DATA_W / 8,
  localparam int unsigned IDX_W   = ADDR_W - 2,
  localparam int unsigned WO_BITS = (N_WO > 0 ? N_WO : 1) * DATA_W,
  localparam int unsigned RW_BITS = (N_RW > 0 ? N_RW : 1) * DATA_W,
  localparam int unsigned RO_BITS = (N_RO > 0 ? N_RO : 1) * DATA_W
) (
  input  logic               aclk,
  input  logic               aresetn,
  input  logic [ADDR_W-1:0]  axil_awaddr,
  input  logic               axil_awvalid,
  output logic               axil_awready,
  input  logic [DATA_W-1:0]  axil_wdata,
  input  logic [STRB_W-1:0]  axil_wstrb,
  input  logic               axil_wvalid,
  output logic               axil_wready,
  output logic [1:0]         axil_bresp,
  output logic               axil_bvalid,
  input  logic               axil_bready,
  input  logic [ADDR_W-1:0]  axil_araddr,
  input  logic               axil_arvalid,
  output logic               axil_arready,
  output logic [DATA_W-1:0]  axil_rdata,
  output logic [1:0]         axil_rresp,
  output logic               axil_rvalid,
  input  logic               axil_rready,
  output logic [WO_BITS-1:0] wo_bus,
  output logic [RW_BITS-1:0] rw_bus,
  input  logic [RO_BITS-1:0] ro_bus
);

  // Reset: asynchronous assert, two-flop synchronous release (R10)
  logic [1:0] rst_pipe;
  logic       rst_n;

  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn) rst_pipe <= 2'b00;
    else          rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  // Write path
  logic              commit;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic [STRB_W-1:0] cmd_strb;
  reg_class_e        wcls;
  logic [IDX_W-1:0]  wloc;
  logic [1:0]        wresp;

  regbank_decode #(.ADDR_W(ADDR_W), .N_WO(N_WO), .N_RW(N_RW), .N_RO(N_RO), .IDX_W(IDX_W))
    u_wdec (.addr(cmd_addr), .cls(wcls), .loc(wloc));

  assign wresp = (wcls == REG_NONE) ? AXI_SLVERR : AXI_OKAY;

  regbank_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)) u_wr (
    .clk(aclk), .rst_n(rst_n),
    .awaddr(axil_awaddr), .awvalid(axil_awvalid), .awready(axil_awready),
    .wdata(axil_wdata), .wstrb(axil_wstrb), .wvalid(axil_wvalid), .wready(axil_wready),
    .bresp(axil_bresp), .bvalid(axil_bvalid), .bready(axil_bready),
    .resp_in(wresp), .commit(commit),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_strb(cmd_strb)
  );

  function automatic logic [DATA_W-1:0] merge_bytes(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [STRB_W-1:0] strb
  );
    logic [DATA_W-1:0] res;
    res = old_v;
    for (int unsigned b = 0; b < STRB_W; b++)
      if (strb[b]) res[8*b +: 8] = new_v[8*b +: 8];
    return res;
  endfunction

  // Software-writable storage, one flop word per register (R2, R3, R4, R6)
  generate
    if (N_WO == 0) begin : g_wo_none
      assign wo_bus = '0;
    end else begin : g_wo
      for (genvar k = 0; k < N_WO; k++) begin : g_reg
        logic [DATA_W-1:0] q, d;
        logic              en;
        always_comb begin
          en = commit && (wcls == REG_WO) && (wloc == IDX_W'(k));
          d  = merge_bytes(q, cmd_data, cmd_strb);
        end
        always_ff @(posedge aclk or negedge rst_n) begin
          if (!rst_n)  q <= '0;
          else if (en) q <= d;
        end
        assign wo_bus[k*DATA_W +: DATA_W] = q;
      end
    end
    if (N_RW == 0) begin : g_rw_none
      assign rw_bus = '0;
    end else begin : g_rw
      for (genvar k = 0; k < N_RW; k++) begin : g_reg
        logic [DATA_W-1:0] q, d;
        logic              en;
        always_comb begin
          en = commit && (wcls == REG_RW) && (wloc == IDX_W'(k));
          d  = merge_bytes(q, cmd_data, cmd_strb);
        end
        always_ff @(posedge aclk or negedge rst_n) begin
          if (!rst_n)  q <= '0;
          else if (en) q <= d;
        end
        assign rw_bus[k*DATA_W +: DATA_W] = q;
      end
    end
  endgenerate

  // Read path
  reg_class_e        rcls;
  logic [IDX_W-1:0]  rloc;
  logic [DATA_W-1:0] rd_word;
  logic [1:0]        rd_resp;

  regbank_decode #(.ADDR_W(ADDR_W), .N_WO(N_WO), .N_RW(N_RW), .N_RO(N_RO), .IDX_W(IDX_W))
    u_rdec (.addr(axil_araddr), .cls(rcls), .loc(rloc));

  always_comb begin
    rd_word = '0;
    rd_resp = AXI_OKAY;
    case (rcls)
      REG_RW:
        for (int unsigned k = 0; k < N_RW; k++)
          if (rloc == IDX_W'(k)) rd_word = rw_bus[k*DATA_W +: DATA_W];
      REG_RO:
        for (int unsigned k = 0; k < N_RO; k++)
          if (rloc == IDX_W'(k)) rd_word = ro_bus[k*DATA_W +: DATA_W];
      REG_NONE: rd_resp = AXI_SLVERR;
      default:  rd_word = '0;
    endcase
  end

  regbank_rd_chan #(.DATA_W(DATA_W)) u_rd (
    .clk(aclk), .rst_n(rst_n),
    .arvalid(axil_arvalid), .arready(axil_arready),
    .rdata(axil_rdata), .rresp(axil_rresp), .rvalid(axil_rvalid), .rready(axil_rready),
    .rd_word(rd_word), .rd_resp(rd_resp)
  );

  // R8: rejected writes leave every register untouched
  a_r8_bad_write_no_change: assert property (@(posedge aclk) disable iff (!rst_n)
    commit && (wcls == REG_NONE) |=> $stable(wo_bus) && $stable(rw_bus));

  // R5: writes aimed at hardware-owned words leave every register untouched
  a_r5_ro_write_no_change: assert property (@(posedge aclk) disable iff (!rst_n)
    commit && (wcls == REG_RO) |=> $stable(wo_bus) && $stable(rw_bus));

  // R6: an all-zero strobe changes nothing
  a_r6_empty_strobe: assert property (@(posedge aclk) disable iff (!rst_n)
    commit && (cmd_strb == '0) |=> $stable(wo_bus) && $stable(rw_bus));

  // R10: registers come out of reset cleared
  a_r10_reset_clear: assert property (@(posedge aclk) disable iff (!rst_n)
    $rose(rst_n) |-> (wo_bus == '0) && (rw_bus == '0));

endmodule

// File: tb/tb_regbank_axil.sv
`timescale 1ns/1ps
module tb_regbank_axil;

  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        aresetn;
  logic [AW-1:0] awaddr, araddr;
  logic        awvalid, wvalid, bready, arvalid, rready;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [63:0] wo_bus, rw_bus, ro_bus;

  logic [31:0] m_wo [2];
  logic [31:0] m_rw [2];
  logic [31:0] ro_val [2];
  assign ro_bus = {ro_val[1], ro_val[0]};

  int n_tests = 0;
  int n_fail  = 0;
  bit check_on = 1'b0;

  always #10 clk = ~clk;

  regbank_axil #(.ADDR_W(AW), .DATA_W(32), .N_WO(2), .N_RW(2), .N_RO(2)) dut (
    .aclk(clk), .aresetn(aresetn),
    .axil_awaddr(awaddr), .axil_awvalid(awvalid), .axil_awready(awready),
    .axil_wdata(wdata), .axil_wstrb(wstrb), .axil_wvalid(wvalid), .axil_wready(wready),
    .axil_bresp(bresp), .axil_bvalid(bvalid), .axil_bready(bready),
    .axil_araddr(araddr), .axil_arvalid(arvalid), .axil_arready(arready),
    .axil_rdata(rdata), .axil_rresp(rresp), .axil_rvalid(rvalid), .axil_rready(rready),
    .wo_bus(wo_bus), .rw_bus(rw_bus), .ro_bus(ro_bus)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  // Reference view of a read: data and response (R1, R3, R4, R5, R8)
  task automatic exp_read(input logic [AW-1:0] a, output logic [31:0] d, output logic [1:0] r);
    int idx = int'(a[AW-1:2]);
    d = 32'h0; r = 2'b00;
    if (a[1:0] != 2'b00 || idx >= 6) r = 2'b10;
    else if (idx >= 4) d = ro_val[idx-4];
    else if (idx >= 2) d = m_rw[idx-2];
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
    int idx = int'(a[AW-1:2]);
    if (a[1:0] != 2'b00) return;
    if (idx < 2)      m_wo[idx]   = merge(m_wo[idx], d, s);
    else if (idx < 4) m_rw[idx-2] = merge(m_rw[idx-2], d, s);
  endtask

  // Per-clock comparison of the hardware-facing buses with the model (R2, R3, R4)
  always begin
    @(posedge clk); #2;
    if (check_on) begin
      check(wo_bus == {m_wo[1], m_wo[0]}, "R2/R3 wo_bus", wo_bus, {m_wo[1], m_wo[0]});
      check(rw_bus == {m_rw[1], m_rw[0]}, "R2/R4 rw_bus", rw_bus, {m_rw[1], m_rw[0]});
    end
  end

  // mode 0: AW and W together, 1: AW first, 2: W first; hold = cycles bready stays low
  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int mode, input int hold, input logic [1:0] exp_resp, input string req);
    bit aw_done = 0, w_done = 0, aw_hs, w_hs, seen = 0;
    awaddr = a; wdata = d; wstrb = s;
    bready = (hold == 0);
    awvalid = (mode != 2);
    wvalid  = (mode != 1);
    for (int c = 0; c < 40 && !seen; c++) begin
      aw_hs = awvalid && awready;
      w_hs  = wvalid && wready;
      @(posedge clk); #1;
      if (aw_hs) begin awvalid = 1'b0; aw_done = 1; end
      if (w_hs)  begin wvalid  = 1'b0; w_done  = 1; end
      if (bvalid) seen = 1;
      else if (aw_done != w_done && !awvalid && !wvalid) begin
        for (int i = 0; i < 3; i++) begin
          @(posedge clk); #1;
          check(!bvalid, "R7 no response with half a write", {63'h0, bvalid}, 64'h0);
        end
        if (!aw_done) awvalid = 1'b1;
        if (!w_done)  wvalid  = 1'b1;
      end
    end
    check(seen, {req, " response seen"}, {63'h0, seen}, 64'h1);
    check(bresp == exp_resp, {req, " bresp"}, {62'h0, bresp}, {62'h0, exp_resp});
    if (exp_resp == 2'b00) model_write(a, d, s);
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); #1;
      check(bvalid && bresp == exp_resp, "R7 response held", {62'h0, bresp}, {62'h0, exp_resp});
      check(!awready && !wready, "R7 no accept while pending", {62'h0, awready, wready}, 64'h0);
    end
    bready = 1'b1;
    @(posedge clk); #1;
    check(!bvalid, "R7 response retires", {63'h0, bvalid}, 64'h0);
    @(posedge clk); #1;
    check(!bvalid, "R7 exactly one response", {63'h0, bvalid}, 64'h0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int hold, input string req);
    logic [31:0] ed, d0;
    logic [1:0]  er;
    bit hs, done = 0, seen = 0;
    araddr = a;
    rready = (hold == 0);
    arvalid = 1'b1;
    exp_read(a, ed, er);
    for (int c = 0; c < 20 && !seen; c++) begin
      hs = arvalid && arready;
      @(posedge clk); #1;
      if (hs) begin arvalid = 1'b0; done = 1; end
      if (rvalid) seen = 1;
    end
    check(seen && done, {req, " read beat"}, {63'h0, seen}, 64'h1);
    check(rdata == ed, {req, " rdata"}, {32'h0, rdata}, {32'h0, ed});
    check(rresp == er, {req, " rresp"}, {62'h0, rresp}, {62'h0, er});
    d0 = rdata;
    for (int i = 0; i < hold; i++) begin
      if (i == 0) ro_val[0] = ro_val[0] + 32'h1;
      @(posedge clk); #1;
      check(rvalid && rdata == d0 && rresp == er, "R9 read beat held", {32'h0, rdata}, {32'h0, d0});
      check(!arready, "R9 arready low while pending", {63'h0, arready}, 64'h0);
    end
    rready = 1'b1;
    @(posedge clk); #1;
    check(!rvalid, "R9 read beat retires", {63'h0, rvalid}, 64'h0);
  endtask

  task automatic apply_reset();
    check_on = 1'b0;
    aresetn = 1'b0;
    #1;
    check(wo_bus == 64'h0 && rw_bus == 64'h0, "R10 async clear", rw_bus, 64'h0);
    check(!bvalid && !rvalid, "R10 handshakes idle", {62'h0, bvalid, rvalid}, 64'h0);
    m_wo[0] = 0; m_wo[1] = 0; m_rw[0] = 0; m_rw[1] = 0;
    repeat (3) @(posedge clk);
    #1 aresetn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(wo_bus == 64'h0 && rw_bus == 64'h0, "R10 cleared after release", wo_bus, 64'h0);
    check(!bvalid && !rvalid, "R10 idle after release", {62'h0, bvalid, rvalid}, 64'h0);
    check_on = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    awaddr = '0; araddr = '0; wdata = '0; wstrb = '0;
    awvalid = 0; wvalid = 0; arvalid = 0; bready = 1; rready = 1;
    ro_val[0] = 32'h1111_2222; ro_val[1] = 32'h3333_4444;
    aresetn = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    apply_reset();

    // R3: write-only slot 0 and its zero read-back
    do_write(6'd0, 32'hFFFF_FFFF, 4'hF, 0, 0, 2'b00, "R3 wo0 write");
    check(wo_bus[31:0] == 32'hFFFF_FFFF, "R2 wo slot 0", wo_bus, 64'hFFFF_FFFF);
    do_read(6'd0, 0, "R3 wo0 read");

    // R1/R4: word 2 is read/write slot 0, AW ahead of W
    do_write(6'd8, 32'hFF00_FF00, 4'hF, 1, 0, 2'b00, "R4 rw0 write");
    check(rw_bus[31:0] == 32'hFF00_FF00, "R1 word2 lands in rw slot 0", rw_bus, 64'hFF00FF00);
    // R7: W ahead of AW, response stalled three cycles
    do_write(6'd12, 32'h5555_5555, 4'hF, 2, 3, 2'b00, "R7 rw1 write");
    check(rw_bus[63:32] == 32'h5555_5555, "R2 rw slot 1", rw_bus, 64'h5555555500000000);
    do_read(6'd8, 0, "R4 rw0 read");
    do_read(6'd12, 0, "R4 rw1 read");

    // R6: partial strobes
    do_write(6'd8, 32'h1234_5678, 4'b0101, 0, 0, 2'b00, "R6 rw0 strobe");
    do_read(6'd8, 0, "R6 rw0 read");
    check(rw_bus[31:0] == 32'hFF34_FF78, "R6 merged bytes", {32'h0, rw_bus[31:0]}, 64'hFF34FF78);
    do_write(6'd4, 32'hA5A5_A5A5, 4'b1000, 2, 0, 2'b00, "R6 wo1 strobe");
    check(wo_bus[63:32] == 32'hA500_0000, "R6 wo1 top byte", {32'h0, wo_bus[63:32]}, 64'hA5000000);
    do_write(6'd12, 32'hDEAD_BEEF, 4'b0000, 0, 0, 2'b00, "R6 empty strobe");

    // R5: hardware-owned words; R9 stall with changing input
    do_write(6'd16, 32'hDEAD_BEEF, 4'hF, 0, 0, 2'b00, "R5 ro write ignored");
    do_read(6'd16, 3, "R5 ro0 read");
    do_read(6'd16, 0, "R5 ro0 reread");
    check(ro_val[0] == 32'h1111_2223, "R5 ro0 new value read", {32'h0, ro_val[0]}, 64'h11112223);
    do_read(6'd20, 0, "R5 ro1 read");

    // R8: out of range and misaligned
    do_write(6'd24, 32'h0BAD_0BAD, 4'hF, 0, 0, 2'b10, "R8 first unmapped word");
    do_write(6'd60, 32'h0BAD_0BAD, 4'hF, 1, 0, 2'b10, "R8 top word");
    do_write(6'd9, 32'h0BAD_0BAD, 4'hF, 2, 0, 2'b10, "R8 misaligned write");
    do_read(6'd24, 0, "R8 unmapped read");
    do_read(6'd60, 0, "R8 top word read");
    do_read(6'd10, 0, "R8 misaligned read");

    // R10: reset in mid-run, then the bank works again
    apply_reset();
    do_write(6'd12, 32'hC0DE_CAFE, 4'hF, 0, 0, 2'b00, "R10 write after reset");
    do_read(6'd12, 0, "R10 read after reset");
    do_read(6'd8, 0, "R10 rw0 cleared");

    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule